// File: doc/BRIEF.md
# Frame-Paced Interrupt Status Controller

This block gathers single-cycle event strobes from the buffer and channel logic into a sticky status byte. It drives an active-low interrupt line toward the host. The line can only become active on a frame tick, which arrives once every 125 µs, so the host sees at most one interrupt per frame. A frame with nothing pending produces no interrupt.

The host finds the cause by reading the status byte. The read strobe may last one or more cycles. Starting a read releases the interrupt line, and finishing it clears the status. Any event that fires while a read is in progress is held aside and merged into the status once the read is over, so no event is lost.

Control is a three-state machine:
- `ST_IDLE`: the line is inactive.
- `ST_ACTIVE`: the line is driven low.
- `ST_DRAIN`: a host read is in progress.

Its transitions:
- IDLE→ACTIVE: a frame tick arrives, status is nonzero and no read is present.
- IDLE→DRAIN and ACTIVE→DRAIN: the read strobe is high.
- DRAIN→IDLE: the read strobe is low again.
- All other cases hold the state.

Top module: `frame_irq_ctrl`

## Requirements
- R1: During and right after reset, `int_n_o` is 1 and `status_o` is zero.
- R2: A strobe on `evt_i[k]`, outside a read, sets `status_o[k]` from the next cycle. Set bits stay set until a read completes. Bit 0 means transmit buffer needs service, bit 1 means receive buffer needs service, and bit 4 means a B-channel buffer is ready.
- R3: `int_n_o` goes low in the cycle after a frame tick is sampled while `status_o` is nonzero and no read is present. A tick with zero status leaves it at 1.
- R4: `int_n_o` never falls except in the cycle after a frame tick. Events arriving between ticks therefore wait for the next tick.
- R5: Once low, `int_n_o` stays low until the read strobe is seen. New events while it is low OR into `status_o` without any other effect on the line.
- R6: From the cycle after the read strobe is first sampled high, `int_n_o` is 1. `status_o` keeps its value for as long as the strobe stays high.
- R7: At the clock edge where the read strobe is first sampled low, `status_o` takes exactly the OR of the events strobed during the read, or zero if there were none.
- R8: A frame tick sampled while the read strobe is high does not assert `int_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | EVT_W | One-cycle event strobes, one per status bit |
| frame_tick_i | input | 1 | One-cycle pulse at each 125 µs frame boundary |
| stat_rd_i | input | 1 | Host read strobe for the status byte, one or more cycles |
| int_n_o | output | 1 | Interrupt line, active low |
| status_o | output | EVT_W | Interrupt status byte |

## Verification
The assertions assume three things about the inputs:
- The read strobe is a plain level that the host holds for whole cycles.
- Frame ticks are single-cycle pulses.
- An event that must count before a tick is strobed at least one cycle before that tick, because the status register needs one edge to capture it.

The stimulus drives every input just after the falling clock edge. It never strobes an event in the same cycle as the tick it is meant to trigger. Read lengths are swept from one to three cycles, with and without a tick and deferred events inside the read.

// File: rtl/fic_pkg.sv
package fic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } fic_state_e;

endpackage

// File: rtl/fic_pace_fsm.sv
module fic_pace_fsm
    import fic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic pending_i,
    input  logic rd_i,
    output logic int_n_o,
    output logic rd_done_o
);

    fic_state_e state_q;
    fic_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_i) begin
                    state_d = ST_DRAIN;
                end else if (tick_i && pending_i) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (rd_i) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!rd_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        int_n_o   = 1'b1;
        rd_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   int_n_o = 1'b1;
            ST_ACTIVE: int_n_o = 1'b0;
            ST_DRAIN:  rd_done_o = !rd_i;
            default:   int_n_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/fic_status_reg.sv
module fic_status_reg #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             rd_i,
    input  logic             rd_done_i,
    output logic [EVT_W-1:0] status_o
);

    logic [EVT_W-1:0] held_q;

    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status_o[b] <= 1'b0;
                held_q[b]   <= 1'b0;
            end else if (rd_i) begin
                // read in flight: park new events
                held_q[b]   <= held_q[b] | evt_i[b];
            end else if (rd_done_i) begin
                // read over: clear, then post parked events
                status_o[b] <= held_q[b] | evt_i[b];
                held_q[b]   <= 1'b0;
            end else begin
                status_o[b] <= status_o[b] | evt_i[b];
            end
        end
    end

endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             frame_tick_i,
    input  logic             stat_rd_i,
    output logic             int_n_o,
    output logic [EVT_W-1:0] status_o
);

    logic pending;
    logic rd_done;

    assign pending = |status_o;

    fic_status_reg #(.EVT_W(EVT_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .rd_i      (stat_rd_i),
        .rd_done_i (rd_done),
        .status_o  (status_o)
    );

    fic_pace_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (frame_tick_i),
        .pending_i (pending),
        .rd_i      (stat_rd_i),
        .int_n_o   (int_n_o),
        .rd_done_o (rd_done)
    );

endmodule

// File: rtl/frame_irq_ctrl_chk.sv
module frame_irq_ctrl_chk #(
    parameter int EVT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [EVT_W-1:0] evt_i,
    input logic             frame_tick_i,
    input logic             stat_rd_i,
    input logic             int_n_o,
    input logic [EVT_W-1:0] status_o
);

    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= stat_rd_i;
        end
    end

    AST_FALL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n_o) |-> ($past(frame_tick_i) && $past(|status_o) && !$past(stat_rd_i))); // R4

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        (!int_n_o && !stat_rd_i) |=> !int_n_o); // R5

    AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        stat_rd_i |=> int_n_o); // R6

    AST_STATUS_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (rst)
        stat_rd_i |=> $stable(status_o)); // R6

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd_i && !rd_q) |=> ((status_o & $past(status_o)) == $past(status_o))); // R2

    AST_TICK_IN_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && frame_tick_i) |=> int_n_o); // R8

    AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd_i && !rd_q) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R2

endmodule

bind frame_irq_ctrl frame_irq_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt_i),
    .frame_tick_i (frame_tick_i),
    .stat_rd_i    (stat_rd_i),
    .int_n_o      (int_n_o),
    .status_o     (status_o)
);

// File: tb/sim_frame_irq_ctrl.sv
`timescale 1ns/1ps
module sim_frame_irq_ctrl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] evt = '0;
    logic         tick = 1'b0;
    logic         rd = 1'b0;
    logic         int_n;
    logic [W-1:0] status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frame_irq_ctrl #(.EVT_W(W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .frame_tick_i (tick),
        .stat_rd_i    (rd),
        .int_n_o      (int_n),
        .status_o     (status)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [W-1:0] es, input logic ei);
        chk(status === es, {req, " status"}, status, es);
        chk(int_n === ei, {req, " int_n"}, {{(W-1){1'b0}}, int_n}, {{(W-1){1'b0}}, ei});
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 in reset", '0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check_out("R1 after reset", '0, 1'b1);

        tick = 1'b1; @(negedge clk); tick = 1'b0;
        check_out("R3 tick with empty status", '0, 1'b1);

        for (int k = 0; k < W; k++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            logic [W-1:0] d;
            int len;
            a   = W'(1) << k;
            b   = W'(1) << ((k + 5) % W);
            d   = (k == W - 1) ? '0 : (W'(1) << ((k + 3) % W));
            len = (k % 3) + 1;

            evt = a; @(negedge clk); evt = '0;
            check_out("R2 event sets bit", a, 1'b1);
            @(negedge clk);
            check_out("R4 waits for tick", a, 1'b1);

            tick = 1'b1; @(negedge clk); tick = 1'b0;
            check_out("R3 tick asserts", a, 1'b0);

            evt = b; @(negedge clk); evt = '0;
            check_out("R5 event while active", a | b, 1'b0);
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            check_out("R5 second tick no change", a | b, 1'b0);

            rd = 1'b1; evt = d; tick = k[0];
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                evt = '0; tick = 1'b0;
                check_out(k[0] ? "R8 tick during read" : "R6 read in flight", a | b, 1'b1);
            end
            rd = 1'b0;
            @(negedge clk);
            check_out("R7 deferred posted", d, 1'b1);
            @(negedge clk);
            check_out("R4 no early reassert", d, 1'b1);

            tick = 1'b1; @(negedge clk); tick = 1'b0;
            check_out("R3 next frame", d, (d == '0));

            if (d != '0) begin
                rd = 1'b1; @(negedge clk);
                check_out("R6 single-cycle read", d, 1'b1);
                rd = 1'b0; @(negedge clk);
                check_out("R7 read clears", '0, 1'b1);
                tick = 1'b1; @(negedge clk); tick = 1'b0;
                check_out("R3 empty after clear", '0, 1'b1);
            end
        end

        // polling read while idle, then reset mid-activity
        evt = 8'h13; @(negedge clk); evt = '0;
        rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
        check_out("R7 polling read clears", '0, 1'b1);
        evt = '1; @(negedge clk); evt = '0;
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        check_out("R3 all bits", '1, 1'b0);
        rst = 1'b1; @(negedge clk);
        check_out("R1 reset clears pending", '0, 1'b1);
        rst = 1'b0; @(negedge clk);
        check_out("R1 after second reset", '0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule